// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a watchdog timer attached to a simple register bus. Software sets up a control register and then has to clear a count register at regular intervals. If the count reaches the selected power-of-two period before it is cleared, the block raises one of three single-cycle requests. The three requests are a non-maskable fast interrupt, an external reset and a system reset. Which one fires depends on a 2-bit response field.

A freeze bit in the control register seals the configuration. Once it has been written as 1, the control register ignores every later write until the block's own reset. Clearing the count still works while sealed, so software can keep servicing a locked watchdog.

The control logic is a four-state machine:
- `ST_IDLE`: unlocked, not counting.
- `ST_RUN`: unlocked, counting.
- `ST_SEAL_OFF`: locked, not counting.
- `ST_SEAL_ON`: locked, counting.

From either unlocked state, a control write moves the machine to the state named by the written enable and freeze bits:
- enable 0, freeze 0 goes to `ST_IDLE`.
- enable 1, freeze 0 goes to `ST_RUN`.
- enable 0, freeze 1 goes to `ST_SEAL_OFF`.
- enable 1, freeze 1 goes to `ST_SEAL_ON`.

Both sealed states have only one transition, a self-loop. Only the reset returns the machine to `ST_IDLE`.

Top module: `lockable_wdt`

## Requirements
- R1: After reset the control byte reads 0, the count reads 0 and all three request outputs are low.
- R2: Control bit 0 enables counting. While it is 0, the count holds its value and no request is raised.
- R3: The period code n in control bits [6:4] sets the timeout to 2^(BASE_EXP+2n) enabled cycles, counted from the clear or enable write. With the default BASE_EXP of 17, code 0 gives 2^17 cycles and code 4 gives 2^25 cycles.
- R4: The response code in control bits [2:1] routes the timeout:
  - 00 and 01 pulse `fiq_req`.
  - 10 pulses `ext_rst_req`.
  - 11 pulses `sys_rst_req`.
  
  Exactly one output is high, and only for one cycle.
- R5: On a timeout the count wraps to 0 and keeps counting, so timeouts repeat once every period while the block stays enabled.
- R6: Writing control bit 3 as 1 seals the control register. Later control writes have no effect until reset.
- R7: Writing 0 to offset 0x34 clears the count, whether or not the block is sealed. A clear in the cycle the count reaches its limit suppresses that timeout.
- R8: Writing a nonzero value to offset 0x34 leaves the count unchanged.
- R9: Reads return data combinationally:
  - Offset 0x30 returns the control byte: enable in bit 0, response in [2:1], freeze in bit 3, period in [6:4].
  - Offset 0x34 returns the count.
  - Any other offset returns 0.
- R10: If the period is shortened below the current count, the timeout fires on the next enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; control writes use bits [7:0] |
| bus_rdata | output | 32 | Read data for bus_addr |
| fiq_req | output | 1 | Fast-interrupt request pulse |
| ext_rst_req | output | 1 | External reset request pulse |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
The bench counts the cycles to each request exactly:
- A compare that is off by one moves the pulse one cycle early or late, and the bench reports it.
- A counter that stops after the first timeout misses the second expected pulse.

The bench also clears the count in the exact cycle of the limit. A design that lets the increment or the timeout win over the clear would raise a pulse that should not appear.

It shortens the period below a running count. A design that uses an equality compare would then let the count run on for a full counter wrap instead of firing on the next cycle.

It tries to rewrite a sealed control register and then services it by clearing the count. A design that gates the clear with the lock would hit an early system-reset request.

// File: rtl/lockable_wdt_pkg.sv
package lockable_wdt_pkg;

    // Register byte offsets; software depends on these positions.
    localparam int unsigned CTRL_OFS = 32'h30;
    localparam int unsigned CNT_OFS  = 32'h34;

    // Number of period codes (3-bit field).
    localparam int unsigned N_PERIODS = 8;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUN      = 2'd1,
        ST_SEAL_OFF = 2'd2,
        ST_SEAL_ON  = 2'd3
    } wdt_state_e;

    typedef struct packed {
        logic [2:0] period;
        logic [1:0] resp;
    } wdt_cfg_t;

endpackage

// File: rtl/wdt_ctrl_fsm.sv
module wdt_ctrl_fsm
    import lockable_wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [6:0] ctrl_wdata,
    output logic       en,
    output logic       locked,
    output wdt_cfg_t   cfg
);

    wdt_state_e state_q, state_d;
    wdt_cfg_t   cfg_q;
    logic       accept;

    // A control write only lands while the machine is in an unlocked state.
    assign accept = ctrl_wr && (state_q == ST_IDLE || state_q == ST_RUN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_RUN: begin
                if (ctrl_wr) begin
                    unique case ({ctrl_wdata[3], ctrl_wdata[0]})
                        2'b00: state_d = ST_IDLE;
                        2'b01: state_d = ST_RUN;
                        2'b10: state_d = ST_SEAL_OFF;
                        2'b11: state_d = ST_SEAL_ON;
                    endcase
                end
            end
            ST_SEAL_OFF: state_d = ST_SEAL_OFF;
            ST_SEAL_ON:  state_d = ST_SEAL_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cfg_q.period <= ctrl_wdata[6:4];
                cfg_q.resp   <= ctrl_wdata[2:1];
            end
        end
    end

    // Output decode from the state register.
    always_comb begin
        en     = 1'b0;
        locked = 1'b0;
        unique case (state_q)
            ST_IDLE:     begin en = 1'b0; locked = 1'b0; end
            ST_RUN:      begin en = 1'b1; locked = 1'b0; end
            ST_SEAL_OFF: begin en = 1'b0; locked = 1'b1; end
            ST_SEAL_ON:  begin en = 1'b1; locked = 1'b1; end
        endcase
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import lockable_wdt_pkg::*;
#(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned BASE_EXP = 17,
    parameter int unsigned PER_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [2:0]       period,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    localparam int unsigned MAX_EXP = BASE_EXP + PER_STEP * (N_PERIODS - 1);

    initial begin
        if (MAX_EXP >= CNT_W) $error("period exponent exceeds counter width");
    end

    logic [CNT_W-1:0] lim_tab [N_PERIODS];
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_q;

    // One terminal value per period code: 2^(BASE+STEP*n) - 1.
    for (genvar n = 0; n < N_PERIODS; n++) begin : g_lim
        localparam int unsigned SH = BASE_EXP + PER_STEP * n;
        assign lim_tab[n] = (CNT_W'(1) << SH) - CNT_W'(1);
    end

    assign limit = lim_tab[period];

    // Greater-or-equal so that shortening the period fires at once.
    assign expire = en && !clr && (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (expire) cnt_q <= '0;
        else if (en)     cnt_q <= cnt_q + CNT_W'(1);
    end

    assign count = cnt_q;

endmodule

// File: rtl/wdt_resp.sv
module wdt_resp (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire,
    input  logic [1:0] resp,
    output logic       fiq_req,
    output logic       ext_rst_req,
    output logic       sys_rst_req
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fiq_req     <= 1'b0;
            ext_rst_req <= 1'b0;
            sys_rst_req <= 1'b0;
        end else begin
            fiq_req     <= expire && !resp[1];
            ext_rst_req <= expire && (resp == 2'b10);
            sys_rst_req <= expire && (resp == 2'b11);
        end
    end

endmodule

// File: rtl/lockable_wdt.sv
module lockable_wdt
    import lockable_wdt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned BASE_EXP = 17,
    parameter int unsigned PER_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              fiq_req,
    output logic              ext_rst_req,
    output logic              sys_rst_req
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(CNT_OFS);

    logic             sel_ctrl, sel_cnt;
    logic             ctrl_wr, cnt_clr;
    logic             en, locked, expire;
    wdt_cfg_t         cfg;
    logic [CNT_W-1:0] count;
    logic [7:0]       ctrl_byte;

    assign sel_ctrl = (bus_addr == A_CTRL);
    assign sel_cnt  = (bus_addr == A_CNT);
    assign ctrl_wr  = bus_we && sel_ctrl;
    assign cnt_clr  = bus_we && sel_cnt && (bus_wdata == 32'd0);

    wdt_ctrl_fsm u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (bus_wdata[6:0]),
        .en         (en),
        .locked     (locked),
        .cfg        (cfg)
    );

    wdt_counter #(
        .CNT_W    (CNT_W),
        .BASE_EXP (BASE_EXP),
        .PER_STEP (PER_STEP)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .clr    (cnt_clr),
        .period (cfg.period),
        .count  (count),
        .expire (expire)
    );

    wdt_resp u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire      (expire),
        .resp        (cfg.resp),
        .fiq_req     (fiq_req),
        .ext_rst_req (ext_rst_req),
        .sys_rst_req (sys_rst_req)
    );

    assign ctrl_byte = {1'b0, cfg.period, locked, cfg.resp, en};

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl)     bus_rdata = {24'd0, ctrl_byte};
        else if (sel_cnt) bus_rdata = 32'(count);
    end

endmodule

// File: rtl/lockable_wdt_chk.sv
module lockable_wdt_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              en,
    input logic              locked,
    input logic [4:0]        cfg_bits,
    input logic [CNT_W-1:0]  count,
    input logic              fiq_req,
    input logic              ext_rst_req,
    input logic              sys_rst_req
);

    logic [2:0] reqs;
    logic       clr_wr, nz_wr;

    assign reqs   = {fiq_req, ext_rst_req, sys_rst_req};
    assign clr_wr = bus_we && (bus_addr == ADDR_W'(lockable_wdt_pkg::CNT_OFS)) && (bus_wdata == 32'd0);
    assign nz_wr  = bus_we && (bus_addr == ADDR_W'(lockable_wdt_pkg::CNT_OFS)) && (bus_wdata != 32'd0);

    assert_onehot_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reqs));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|reqs) |=> !(|reqs));

    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (reqs == 3'b000));

    assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr_wr) |=> $stable(count));

    assert_seal_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(en) && $stable(cfg_bits)));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (count == '0 && reqs == 3'b000));

    assert_nonzero_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (nz_wr && !en) |=> $stable(count));

endmodule

bind lockable_wdt lockable_wdt_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .en          (en),
    .locked      (locked),
    .cfg_bits    (cfg),
    .count       (count),
    .fiq_req     (fiq_req),
    .ext_rst_req (ext_rst_req),
    .sys_rst_req (sys_rst_req)
);

// File: tb/tb_lockable_wdt.sv
module tb_lockable_wdt;

    localparam int BASE = 4;   // code n -> 2^(4+2n) cycles in the bench
    localparam logic [7:0] A_CTRL = 8'h30;
    localparam logic [7:0] A_CNT  = 8'h34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fiq_req, ext_rst_req, sys_rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    lockable_wdt #(.ADDR_W(8), .CNT_W(32), .BASE_EXP(BASE), .PER_STEP(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fiq_req(fiq_req),
        .ext_rst_req(ext_rst_req), .sys_rst_req(sys_rst_req));

    function automatic int per(input int code);
        return 1 << (BASE + 2 * code);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    function automatic logic [2:0] reqs();
        return {fiq_req, ext_rst_req, sys_rst_req};
    endfunction

    // After a write whose edge is E (task returns before E+1): check
    // nothing at E+P-1, the expected pulse at E+P, nothing at E+P+1.
    task automatic expect_pulse(input int p, input logic [2:0] exp, input string req);
        repeat (p - 1) @(posedge clk);
        #1 check(reqs() == 3'b000, req, reqs(), 0);
        @(posedge clk);
        #1 check(reqs() == exp, req, reqs(), exp);
        @(posedge clk);
        #1 check(reqs() == 3'b000, req, reqs(), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(A_CTRL, d); check(d == 0, "R1 ctrl", d, 0);
        rd(A_CNT, d);  check(d == 0, "R1 count", d, 0);
        check(reqs() == 0, "R1 outputs", reqs(), 0);
        rd(8'h38, d);  check(d == 0, "R9 unmapped", d, 0);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        bit seen = 0;
        wr(A_CTRL, 32'h00);
        repeat (3 * per(0)) begin
            @(posedge clk); #1 if (reqs() != 0) seen = 1;
        end
        check(!seen, "R2 no request while disabled", seen, 0);
        rd(A_CNT, d); check(d == 0, "R2 count held", d, 0);
    endtask

    task automatic t_fiq_repeat();
        wr(A_CTRL, 32'h01);                       // enable, resp 00, code 0
        expect_pulse(per(0), 3'b100, "R3 R4 fiq code0");
        expect_pulse(per(0) - 1, 3'b100, "R5 wrap repeat");
    endtask

    task automatic t_hold_and_clear();
        logic [31:0] v, d;
        wr(A_CTRL, 32'h00);
        rd(A_CNT, v);
        repeat (5) @(negedge clk);
        rd(A_CNT, d); check(d == v, "R2 hold on disable", d, v);
        wr(A_CNT, 32'h1234);
        rd(A_CNT, d); check(d == v, "R8 nonzero write ignored", d, v);
        wr(A_CNT, 32'h0);
        rd(A_CNT, d); check(d == 0, "R7 clear", d, 0);
        rd(A_CTRL, d); check(d == 0, "R9 ctrl readback", d, 0);
    endtask

    task automatic t_responses();
        logic [31:0] d;
        for (int r = 1; r < 4; r++) begin
            logic [2:0] exp;
            exp = (r == 1) ? 3'b100 : (r == 2) ? 3'b010 : 3'b001;
            wr(A_CTRL, 32'h00);
            wr(A_CNT, 32'h0);
            wr(A_CTRL, 32'h11 | (r << 1));       // code 1
            rd(A_CTRL, d);
            check(d == (32'h11 | (r << 1)), "R9 ctrl fields", d, 32'h11 | (r << 1));
            expect_pulse(per(1) - 0, exp, "R4 response route");
        end
        wr(A_CTRL, 32'h00); wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h21);                       // code 2, fiq
        expect_pulse(per(2), 3'b100, "R3 code2 period");
    endtask

    task automatic t_terminal_clear();
        logic [31:0] d;
        wr(A_CTRL, 32'h00); wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h01);
        repeat (per(0) - 1) @(negedge clk);
        bus_addr = A_CNT; bus_we = 1'b1; bus_wdata = 0;
        @(posedge clk);
        #1 check(reqs() == 0, "R7 clear at limit suppresses", reqs(), 0);
        @(negedge clk); bus_we = 1'b0;
        @(posedge clk);
        #1 check(reqs() == 0, "R7 no late pulse", reqs(), 0);
        rd(A_CNT, d); check(d == 1, "R7 restart from zero", d, 1);
    endtask

    task automatic t_shorten();
        wr(A_CTRL, 32'h00); wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h21);
        repeat (100) @(negedge clk);
        wr(A_CTRL, 32'h01);
        @(posedge clk);
        #1 check(reqs() == 3'b100, "R10 shorten fires next cycle", reqs(), 3'b100);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        wr(A_CTRL, 32'h00); wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h0F);                       // seal, sys reset, code 0
        expect_pulse(per(0), 3'b001, "R6 sealed sys request");
        wr(A_CTRL, 32'h00);
        rd(A_CTRL, d); check(d == 32'h0F, "R6 write ignored", d, 32'h0F);
        wr(A_CNT, 32'h0);
        expect_pulse(per(0), 3'b001, "R7 clear while sealed");
        do_reset();
        rd(A_CTRL, d); check(d == 0, "R6 reset unseals", d, 0);
        wr(A_CTRL, 32'h03);
        rd(A_CTRL, d); check(d == 32'h03, "R6 writable after reset", d, 3);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_disabled();
        t_fiq_repeat();
        t_hold_and_clear();
        t_responses();
        t_terminal_clear();
        t_shorten();
        t_lock();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule